// File: doc/BRIEF.md
# Programmable Three-Port Parallel Interface

This block gives a processor three 8-bit parallel ports, named A, B and C, whose directions are chosen by software. Port C is handled as two 4-bit halves that can be pointed in different directions. The processor reaches the block through a chip select, separate read and write strobes, a two-bit register address, and separate write-data and read-data buses. Every port has its own input bus and its own output bus, and port C's buses are split into an upper nibble and a lower nibble.

One control register sets the configuration. A word written there with its top bit set is a mode word. It sets the direction of port A, port B, upper C and lower C, and it clears every output latch. A word written there with its top bit clear changes a single port C output bit and leaves the directions as they are. Ports A and B take their input through a sampling register. Port C inputs go straight to the read-data bus. An output port drives its latch onto its output bus. An input port drives zero onto its output bus.

Only the basic input/output configuration is built. The mode-select field of a mode word is accepted but ignored, and it reads back as zero.

Top module: `ppi_core`

## Requirements
- R1: While `rst_n` is low, all output buses are 0, asynchronously. Once reset is over, all four port groups are inputs and the control register reads 8'h9B.
- R2: The register addresses are 2'b00 port A, 2'b01 port B, 2'b10 port C and 2'b11 control. A write takes effect only when `cs` and `wr` are both high at a clock edge.
- R3: A mode word has bit 7 = 1. In it, bit 4 sets port A, bit 3 sets upper C, bit 1 sets port B and bit 0 sets lower C, with 1 meaning input and 0 meaning output. Reading the control register returns {1, 2'b00, bit4, bit3, 1'b0, bit1, bit0}, so bits 7 and 6:5 and 2 read back as 1, 0 and 0 whatever was written.
- R4: Writing a mode word sets the output latches of A, B and C to 0 from the next cycle on.
- R5: A data write to a port sets that port's output latch. For an output port or port C half, the latch value appears on its output bus in the cycle after the write and is returned when that port is read.
- R6: An input port A or B drives 0 on its output bus. A read of that port returns the pin value that was sampled at the last clock edge. Sampling is frozen at every edge during which that port is being read.
- R7: A port C half configured as input returns its live pins on a read in the same cycle, with no register in the path. Each half follows its own direction bit.
- R8: A control write with bit 7 = 0 sets port C output bit number bits 3:1 to the value in bit 0. It leaves the other latch bits, port A, port B and the directions unchanged.
- R9: When `cs`, `rd` and `wr` are all high in the same cycle, the read data shows the state from before the write, and the write takes effect at that clock edge.
- R10: The read-data bus is 0 unless both `cs` and `rd` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Register address |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A drive out |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B drive out |
| pch_in | input | 4 | Port C upper nibble pins in |
| pch_out | output | 4 | Port C upper nibble drive out |
| pcl_in | input | 4 | Port C lower nibble pins in |
| pcl_out | output | 4 | Port C lower nibble drive out |

## Verification
A read and a write can land in the same cycle, on the same register. The bench raises `rd` and `wr` together, once on port A and once on the control register. It checks that the read data first shows the old latch or configuration and then, while the strobe is still held past the edge, shows the new one.

A second collision is a port A read held across an edge while the pins change. The bench judges this by requiring that the returned value stays at the old sample. The new sample must appear only on a read that comes after the hold is released.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CTL = 2'b11
  } sel_e;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic ch_in;
    logic cl_in;
  } dir_t;

  localparam int unsigned CW_KIND  = 7;
  localparam int unsigned CW_A_DIR = 4;
  localparam int unsigned CW_CH_DIR = 3;
  localparam int unsigned CW_B_DIR = 1;
  localparam int unsigned CW_CL_DIR = 0;
  localparam int unsigned CW_BIT_VAL = 0;

endpackage

// File: rtl/ppi_rst_sync.sv
module ppi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[STAGES-1];

endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
#(
  parameter int W = 8,
  parameter int SIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [W-1:0]      wdata,
  output dir_t              dir,
  output logic              mode_load,
  output logic              bsr_en,
  output logic [SIDX_W-1:0] bsr_idx,
  output logic              bsr_val,
  output logic [W-1:0]      ctl_rdata
);

  dir_t dir_q, dir_d;
  logic unused_mode_sel;

  assign unused_mode_sel = ^{wdata[W-2:CW_A_DIR+1], wdata[CW_B_DIR+1]};

  assign mode_load = ctl_we &  wdata[CW_KIND];
  assign bsr_en    = ctl_we & ~wdata[CW_KIND];
  assign bsr_idx   = wdata[SIDX_W:1];
  assign bsr_val   = wdata[CW_BIT_VAL];

  always_comb begin
    dir_d = dir_q;
    if (mode_load) begin
      dir_d.a_in  = wdata[CW_A_DIR];
      dir_d.b_in  = wdata[CW_B_DIR];
      dir_d.ch_in = wdata[CW_CH_DIR];
      dir_d.cl_in = wdata[CW_CL_DIR];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dir_q <= '1;
    else if (mode_load) dir_q <= dir_d;
  end

  always_comb begin
    ctl_rdata            = '0;
    ctl_rdata[CW_KIND]   = 1'b1;
    ctl_rdata[CW_A_DIR]  = dir_q.a_in;
    ctl_rdata[CW_CH_DIR] = dir_q.ch_in;
    ctl_rdata[CW_B_DIR]  = dir_q.b_in;
    ctl_rdata[CW_CL_DIR] = dir_q.cl_in;
  end

  assign dir = dir_q;

  // R8: a single-bit command leaves the configuration alone
  assert_bsr_keeps_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_en |=> $stable(dir_q));

  // R3: mode word bit 4 becomes the port A direction
  assert_mode_loads_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> (dir_q.a_in == $past(wdata[CW_A_DIR])));

endmodule

// File: rtl/ppi_port.sv
module ppi_port #(
  parameter int W          = 8,
  parameter bit LATCHED_IN = 1'b1,
  parameter int SET_BASE   = 0,
  parameter int SIDX_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [W-1:0]      wdata,
  input  logic              set_en,
  input  logic [SIDX_W-1:0] set_idx,
  input  logic              set_val,
  input  logic              is_input,
  input  logic              hold,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      rd_data
);

  logic [W-1:0] out_q, out_d;
  logic [W-1:0] in_val;

  always_comb begin
    out_d = out_q;
    if (clr) begin
      out_d = '0;
    end else if (wr_en) begin
      out_d = wdata;
    end else if (set_en) begin
      for (int i = 0; i < W; i++) begin
        if (int'(set_idx) == SET_BASE + i) out_d[i] = set_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  generate
    if (LATCHED_IN) begin : g_latch
      logic [W-1:0] in_q, in_d;

      always_comb begin
        in_d = hold ? in_q : pin_in;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= in_d;
      end

      assign in_val = in_q;

      // R6: sampling is frozen while the port is being read
      assert_hold_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (in_q == $past(in_q)));
    end else begin : g_live
      logic unused_hold;
      assign unused_hold = hold;
      assign in_val      = pin_in;
    end
  endgenerate

  assign rd_data = is_input ? in_val : out_q;
  assign pin_out = is_input ? '0 : out_q;

  // R4: a mode word empties the output latch
  assert_mode_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (out_q == '0));

  // R5: a data write lands in the latch one cycle later
  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (out_q == $past(wdata)));

endmodule

// File: rtl/ppi_core.sv
module ppi_core
  import ppi_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] dout,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  input  logic [PW/2-1:0] pch_in,
  output logic [PW/2-1:0] pch_out,
  input  logic [PW/2-1:0] pcl_in,
  output logic [PW/2-1:0] pcl_out
);

  localparam int HW     = PW / 2;
  localparam int SIDX_W = $clog2(PW);

  logic              rst_sync_n;
  sel_e              sel;
  logic              we, re;
  dir_t              dir;
  logic              mode_load, bsr_en, bsr_val;
  logic [SIDX_W-1:0] bsr_idx;
  logic [PW-1:0]     ctl_rdata, pa_rd, pb_rd;
  logic [PW-1:0]     pc_pins, pc_drv, pc_rd;
  logic [1:0]        pc_half_in;

  ppi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign sel = sel_e'(addr);
  assign we  = cs & wr;
  assign re  = cs & rd;

  ppi_ctrl #(.W(PW), .SIDX_W(SIDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctl_we    (we && sel == SEL_CTL),
    .wdata     (din),
    .dir       (dir),
    .mode_load (mode_load),
    .bsr_en    (bsr_en),
    .bsr_idx   (bsr_idx),
    .bsr_val   (bsr_val),
    .ctl_rdata (ctl_rdata)
  );

  ppi_port #(.W(PW), .LATCHED_IN(1'b1), .SET_BASE(0), .SIDX_W(SIDX_W)) u_pa (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (mode_load),
    .wr_en    (we && sel == SEL_A),
    .wdata    (din),
    .set_en   (1'b0),
    .set_idx  ('0),
    .set_val  (1'b0),
    .is_input (dir.a_in),
    .hold     (re && sel == SEL_A),
    .pin_in   (pa_in),
    .pin_out  (pa_out),
    .rd_data  (pa_rd)
  );

  ppi_port #(.W(PW), .LATCHED_IN(1'b1), .SET_BASE(0), .SIDX_W(SIDX_W)) u_pb (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (mode_load),
    .wr_en    (we && sel == SEL_B),
    .wdata    (din),
    .set_en   (1'b0),
    .set_idx  ('0),
    .set_val  (1'b0),
    .is_input (dir.b_in),
    .hold     (re && sel == SEL_B),
    .pin_in   (pb_in),
    .pin_out  (pb_out),
    .rd_data  (pb_rd)
  );

  assign pc_pins    = {pch_in, pcl_in};
  assign pc_half_in = {dir.ch_in, dir.cl_in};

  generate
    for (genvar h = 0; h < 2; h++) begin : g_pc
      ppi_port #(.W(HW), .LATCHED_IN(1'b0), .SET_BASE(h*HW), .SIDX_W(SIDX_W)) u_half (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .clr      (mode_load),
        .wr_en    (we && sel == SEL_C),
        .wdata    (din[h*HW +: HW]),
        .set_en   (bsr_en),
        .set_idx  (bsr_idx),
        .set_val  (bsr_val),
        .is_input (pc_half_in[h]),
        .hold     (1'b0),
        .pin_in   (pc_pins[h*HW +: HW]),
        .pin_out  (pc_drv[h*HW +: HW]),
        .rd_data  (pc_rd[h*HW +: HW])
      );
    end
  endgenerate

  assign pch_out = pc_drv[PW-1:HW];
  assign pcl_out = pc_drv[HW-1:0];

  always_comb begin
    dout = '0;
    if (re) begin
      case (sel)
        SEL_A:   dout = pa_rd;
        SEL_B:   dout = pb_rd;
        SEL_C:   dout = pc_rd;
        default: dout = ctl_rdata;
      endcase
    end
  end

  // R3: control readback always carries the mode-word marker
  assert_ctl_marker_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (re && sel == SEL_CTL) |-> dout[CW_KIND]);

  // R10: no read strobe, quiet bus
  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !re |-> (dout == '0));

  // R5: an output port A shows the written byte on its pins next cycle
  assert_pa_drive_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (we && sel == SEL_A && !dir.a_in) |=> (pa_out == $past(din)));

  // R6: an input port B drives nothing
  assert_pb_quiet_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_load && din[CW_B_DIR]) |=> (pb_out == '0));

endmodule

// File: tb/tb_ppi_core.sv
module tb_ppi_core;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs, rd, wr;
  logic [1:0] addr;
  logic [7:0] din, dout;
  logic [7:0] pa_in, pa_out, pb_in, pb_out;
  logic [3:0] pch_in, pch_out, pcl_in, pcl_out;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ppi_core dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .din(din), .dout(dout),
    .pa_in(pa_in), .pa_out(pa_out), .pb_in(pb_in), .pb_out(pb_out),
    .pch_in(pch_in), .pch_out(pch_out), .pcl_in(pcl_in), .pcl_out(pcl_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; din = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 v = dout;
    #1 cs = 1'b0; rd = 1'b0;
  endtask

  task automatic rd_now(input logic [1:0] a, output logic [7:0] v);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 v = dout;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] v, cw, exp_rb, va, vb, vc, cmodel;
    cs = 0; rd = 0; wr = 0; addr = 0; din = 0;
    pa_in = 0; pb_in = 0; pch_in = 0; pcl_in = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    do_rd(2'b11, v); chk("R1 ctl readback", v, 8'h9B);
    chk("R1 pa_out", pa_out, 8'h00);
    chk("R1 pb_out", pb_out, 8'h00);
    chk("R1 pc_out", {pch_out, pcl_out}, 8'h00);

    // R3 R4 R5 R6 R7: sweep every direction combination
    for (int m = 0; m < 16; m++) begin
      logic a_i, ch_i, b_i, cl_i;
      a_i = m[3]; ch_i = m[2]; b_i = m[1]; cl_i = m[0];
      cw = 8'h80 | (8'(a_i) << 4) | (8'(ch_i) << 3) | (8'(b_i) << 1) | 8'(cl_i);
      exp_rb = cw;
      do_wr(2'b11, cw | 8'h64);
      do_rd(2'b11, v); chk("R3 ctl readback", v, exp_rb);
      chk("R4 pa_out cleared", pa_out, 8'h00);
      chk("R4 pb_out cleared", pb_out, 8'h00);
      chk("R4 pc_out cleared", {pch_out, pcl_out}, 8'h00);
      va = 8'(m * 17) ^ 8'hA5;
      vb = 8'(m * 29) ^ 8'h3C;
      vc = 8'(m * 13) ^ 8'h96;
      pa_in = ~va; pb_in = vb ^ 8'hFF; {pch_in, pcl_in} = ~vc;
      do_wr(2'b00, va);
      do_wr(2'b01, vb);
      do_wr(2'b10, vc);
      chk("R5/R6 pa_out", pa_out, a_i ? 8'h00 : va);
      chk("R5/R6 pb_out", pb_out, b_i ? 8'h00 : vb);
      chk("R5/R7 pc_out", {pch_out, pcl_out},
          {ch_i ? 4'h0 : vc[7:4], cl_i ? 4'h0 : vc[3:0]});
      do_rd(2'b00, v); chk("R2/R6 read A", v, a_i ? ~va : va);
      do_rd(2'b01, v); chk("R2/R6 read B", v, b_i ? (vb ^ 8'hFF) : vb);
      do_rd(2'b10, v); chk("R2/R7 read C", v,
          {ch_i ? ~vc[7:4] : vc[7:4], cl_i ? ~vc[3:0] : vc[3:0]});
    end

    // R7: live port C pins, lower half input, upper half output
    do_wr(2'b11, 8'h81);
    do_wr(2'b10, 8'hC0);
    @(negedge clk);
    pcl_in = 4'h7; pch_in = 4'h2;
    rd_now(2'b10, v); chk("R7 live lower half", v, 8'hC7);
    pcl_in = 4'hE;
    rd_now(2'b10, v); chk("R7 live lower half change", v, 8'hCE);

    // R2 R10: chip select gating
    do_wr(2'b11, 8'h80);
    do_wr(2'b00, 8'h5A);
    @(negedge clk);
    cs = 1'b0; wr = 1'b1; addr = 2'b00; din = 8'hFF;
    @(negedge clk);
    wr = 1'b0;
    chk("R2 write without cs ignored", pa_out, 8'h5A);
    rd = 1'b1; addr = 2'b00;
    #1 chk("R10 read without cs", dout, 8'h00);
    rd = 1'b0; cs = 1'b1;
    #1 chk("R10 cs without rd", dout, 8'h00);
    cs = 1'b0;

    // R8: single-bit commands on port C, all outputs
    do_wr(2'b10, 8'h00);
    cmodel = 8'h00;
    for (int i = 0; i < 8; i++) begin
      do_wr(2'b11, 8'(i << 1) | 8'h01);
      cmodel[i] = 1'b1;
      chk("R8 set bit", {pch_out, pcl_out}, cmodel);
    end
    for (int i = 0; i < 8; i += 2) begin
      do_wr(2'b11, 8'(i << 1));
      cmodel[i] = 1'b0;
      chk("R8 clear bit", {pch_out, pcl_out}, cmodel);
    end
    chk("R8 port A untouched", pa_out, 8'h5A);
    do_rd(2'b11, v); chk("R8 directions kept", v, 8'h80);

    // R6: sampling frozen across a held read
    do_wr(2'b11, 8'h9B);
    pa_in = 8'h12;
    @(negedge clk);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = 2'b00;
    #1 chk("R6 sampled value", dout, 8'h12);
    pa_in = 8'h34;
    @(negedge clk);
    #1 chk("R6 frozen during read", dout, 8'h12);
    cs = 1'b0; rd = 1'b0;
    do_rd(2'b00, v); chk("R6 resampled after read", v, 8'h34);

    // R9: read and write in the same cycle
    do_wr(2'b11, 8'h80);
    do_wr(2'b00, 8'h0F);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; wr = 1'b1; addr = 2'b00; din = 8'hF0;
    #1 chk("R9 old data before edge", dout, 8'h0F);
    @(negedge clk);
    wr = 1'b0;
    #1 chk("R9 new data after edge", dout, 8'hF0);
    wr = 1'b1; addr = 2'b11; din = 8'h9B;
    #1 chk("R9 old config before edge", dout, 8'h80);
    @(negedge clk);
    wr = 1'b0;
    #1 chk("R9 new config after edge", dout, 8'h9B);
    cs = 1'b0; rd = 1'b0;

    // R1: asynchronous reset in mid-run
    do_wr(2'b11, 8'h80);
    do_wr(2'b00, 8'hFF);
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 async clear", pa_out, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_rd(2'b11, v); chk("R1 readback after reset", v, 8'h9B);

    done = 1'b1;
    summary();
  end

endmodule